// File: doc/BRIEF.md
# PHY Autonegotiation Bring-Up Sequencer

This block brings an external Ethernet PHY from power-up to a negotiated link. It needs no software. It sits beside an MDIO master and sends it one register access at a time. The sequence runs in this order:

1. Reset the PHY and poll until the reset completes.
2. Mask every PHY interrupt.
3. Build the advertisement word from the capability bits of the status register.
4. Write the advertisement word, then read it back once.
5. Restart autonegotiation and poll until the PHY acknowledges completion.

If a poll reports a remote fault, the sequencer forces speed and duplex in a restart write and keeps polling.

A slow timebase tick spaces the polls. Each wait between polls is a fixed number of ticks. When the sequence ends, a done flag goes high together with the outcome: link up, reset timeout, negotiation timeout or remote fault. A new start pulse clears the outcome and runs the sequence again.

Top module: `phy_bringup_seq`

## Requirements
- R1: While reset is held and after it is released, all status outputs and `mdio_req` are 0 until `start` is seen.
- R2: On `start`, the first access writes 0x8000 (reset bit 15 only) to the control register (default register 0).
- R3: The control register is read until bit 15 reads 0, up to RST_POLLS reads in total. The first read follows the reset write at once, and each later read starts POLL_TICKS ticks after the previous one completed.
- R4: If all RST_POLLS reads show bit 15 set, the block finishes with `rst_timeout`=1 and makes no further access.
- R5: After the reset clears, 0xFFFF is written to the interrupt-mask register (default 19), followed by one read of the status register (default 1).
- R6: The advertisement word is 0x0001 plus one bit per status capability. Status bits 15, 14, 13, 12 and 11 map to advertisement bits 9, 8, 7, 6 and 5. The word is written to the advertisement register (default 4), and that register is then read exactly once.
- R7: Negotiation restarts with a write of 0x1200 (enable bit 12, restart bit 9) to the control register.
- R8: The status register is then polled up to 2*ANEG_TIMEOUT times until bit 5 is set. The first poll is immediate, and later polls are spaced by POLL_TICKS ticks.
- R9: A poll with bit 5 clear and bit 4 (remote fault) set is followed at once by a write of 0x3300 (bits 13, 12, 9, 8) to the control register.
- R10: When the poll budget runs out without bit 5, the block finishes with `aneg_timeout`=1.
- R11: At the finish, `remote_fault` equals bit 4 of the last status poll, and `link_up` is 1 only when bit 5 was seen with bit 4 clear.
- R12: Only one access is outstanding at a time. The register, direction and write data stay stable from the assertion of `mdio_req` until `mdio_done`.
- R13: `start` has no effect while a sequence runs. After the finish, `start` clears every status output on the next cycle and repeats the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin a bring-up sequence |
| tick | input | 1 | One-cycle pulse of the slow polling timebase |
| mdio_req | output | 1 | Access request to the MDIO master, held until done |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_reg | output | 5 | PHY register number |
| mdio_wdata | output | 16 | Write data |
| mdio_rdata | input | 16 | Read data, valid with `mdio_done` |
| mdio_done | input | 1 | One-cycle completion of the current access |
| bring_done | output | 1 | Sequence finished, outcome valid |
| link_up | output | 1 | Negotiation acknowledged without remote fault |
| rst_timeout | output | 1 | PHY reset never cleared |
| aneg_timeout | output | 1 | Negotiation never acknowledged |
| remote_fault | output | 1 | Last status poll reported remote fault |

## Verification
Most internal mistakes show up in the access stream on the MDIO port. A wrong state transition, a miscounted poll budget or a wrong word shows as a missing, extra or altered access, visible within one access of the fault. The bench runs the sequence against a modelled PHY and compares every access in order. The sweeps cover every reset-clear count, all 32 capability patterns, every acknowledge position and several fault patterns. A broken tick counter shows as a wrong tick gap between consecutive polls. A flag error shows in the cycle `bring_done` rises.

// File: rtl/phy_bringup_pkg.sv
// Package: shared state encoding and clause-22 bit positions for the PHY
// bring-up sequencer. Assumes 16-bit management registers.
package phy_bringup_pkg;

    localparam int DATA_W = 16;
    localparam int REG_W  = 5;

    // Control register bits
    localparam int CTL_RESET_BIT   = 15;
    localparam int CTL_SPEED_BIT   = 13;
    localparam int CTL_AN_EN_BIT   = 12;
    localparam int CTL_AN_RST_BIT  = 9;
    localparam int CTL_DUPLEX_BIT  = 8;

    // Status register bits
    localparam int ST_AN_DONE_BIT  = 5;
    localparam int ST_RFAULT_BIT   = 4;

    // Capability -> advertisement mapping (T4, 100F, 100H, 10F, 10H)
    localparam int NUM_CAPS = 5;
    localparam int unsigned CAP_BIT [0:NUM_CAPS-1] = '{15, 14, 13, 12, 11};
    localparam int unsigned ADV_BIT [0:NUM_CAPS-1] = '{9, 8, 7, 6, 5};

    localparam logic [DATA_W-1:0] ADV_SELECTOR = 16'h0001;
    localparam logic [DATA_W-1:0] MASK_ALL     = 16'hFFFF;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_RST,
        S_RD_CTRL,
        S_WAIT_RST,
        S_WR_MASK,
        S_RD_CAPS,
        S_WR_ADV,
        S_RD_ADV,
        S_WR_ANEG,
        S_RD_STAT,
        S_WR_FORCE,
        S_WAIT_AN,
        S_DONE
    } seq_state_t;

    function automatic logic [DATA_W-1:0] bit_word(input int pos);
        return DATA_W'(1) << pos;
    endfunction

endpackage

// File: rtl/pbu_adv_builder.sv
// Module: maps the PHY's capability bits to the advertisement word.
// Assumes caps[i] holds the status bit CAP_BIT[i]; purely combinational.
module pbu_adv_builder
    import phy_bringup_pkg::*;
(
    input  logic [NUM_CAPS-1:0] caps,
    output logic [DATA_W-1:0]   adv
);

    logic [DATA_W-1:0] part [NUM_CAPS];

    for (genvar g = 0; g < NUM_CAPS; g++) begin : g_cap
        // one advertisement bit per capability
        assign part[g] = caps[g] ? bit_word(int'(ADV_BIT[g])) : '0;
    end

    // merge selector field with all capability bits
    always_comb begin
        adv = ADV_SELECTOR;
        for (int i = 0; i < NUM_CAPS; i++) begin
            adv = adv | part[i];
        end
    end

endmodule

// File: rtl/pbu_poll_timer.sv
// Module: counts slow timebase ticks while `run` is high and pulses `expire`
// on the TICKS-th tick. Assumes the caller drops `run` after expiry.
module pbu_poll_timer #(
    parameter int TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);

    localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    // tick counter, cleared whenever the wait is not active
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // expiry on the last tick of the window
    always_comb begin
        expire = run && tick && (cnt == LAST);
    end

    a_r3_timer_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= LAST));

    a_r8_timer_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/pbu_poll_budget.sv
// Module: down-counter of remaining polls. Loaded at the start of a poll
// loop, decremented per unsuccessful poll. Assumes load and dec never coincide.
module pbu_poll_budget #(
    parameter int MAXN = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [$clog2(MAXN+1)-1:0] load_val,
    input  logic         dec,
    output logic         is_one,
    output logic         is_zero
);

    localparam int BW = $clog2(MAXN + 1);

    logic [BW-1:0] left;

    // remaining-poll register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (load) begin
            left <= load_val;
        end else if (dec) begin
            left <= left - 1'b1;
        end
    end

    // boundary flags for the sequencer
    always_comb begin
        is_one  = (left == BW'(1));
        is_zero = (left == '0);
    end

    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !is_zero);

    a_r3_load_dec_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec));

endmodule

// File: rtl/phy_bringup_seq.sv
// Module: top of the PHY bring-up sequencer. Issues single MDIO accesses
// through a request/done handshake: reset, interrupt mask, advertisement,
// negotiation restart and polling. Assumes mdio_done pulses one cycle per
// request and tick is a one-cycle pulse of the slow timebase.
module phy_bringup_seq
    import phy_bringup_pkg::*;
#(
    parameter int          POLL_TICKS   = 5,
    parameter int          RST_POLLS    = 6,
    parameter int          ANEG_TIMEOUT = 10,
    parameter logic [4:0]  CTRL_REG     = 5'd0,
    parameter logic [4:0]  STAT_REG     = 5'd1,
    parameter logic [4:0]  ADV_REG      = 5'd4,
    parameter logic [4:0]  MASK_REG     = 5'd19
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        tick,
    output logic        mdio_req,
    output logic        mdio_wr,
    output logic [4:0]  mdio_reg,
    output logic [15:0] mdio_wdata,
    input  logic [15:0] mdio_rdata,
    input  logic        mdio_done,
    output logic        bring_done,
    output logic        link_up,
    output logic        rst_timeout,
    output logic        aneg_timeout,
    output logic        remote_fault
);

    localparam int AN_POLLS   = 2 * ANEG_TIMEOUT;
    localparam int BUDGET_MAX = (AN_POLLS > RST_POLLS) ? AN_POLLS : RST_POLLS;
    localparam int BW         = $clog2(BUDGET_MAX + 1);

    localparam logic [DATA_W-1:0] CTRL_RESET_WORD = bit_word(CTL_RESET_BIT);
    localparam logic [DATA_W-1:0] CTRL_ANEG_WORD  =
        bit_word(CTL_AN_EN_BIT) | bit_word(CTL_AN_RST_BIT);
    localparam logic [DATA_W-1:0] CTRL_FORCE_WORD =
        CTRL_ANEG_WORD | bit_word(CTL_SPEED_BIT) | bit_word(CTL_DUPLEX_BIT);

    seq_state_t        state;
    logic [DATA_W-1:0] adv_q;
    logic [DATA_W-1:0] adv_word;
    logic [NUM_CAPS-1:0] caps;
    logic              timer_run;
    logic              timer_expire;
    logic              bud_load;
    logic [BW-1:0]     bud_val;
    logic              bud_dec;
    logic              bud_one;
    logic              bud_zero;
    logic              rst_busy;
    logic              an_ack;
    logic              an_fault;

    // decode of the status bits the sequencer reacts to
    always_comb begin
        rst_busy = mdio_rdata[CTL_RESET_BIT];
        an_ack   = mdio_rdata[ST_AN_DONE_BIT];
        an_fault = mdio_rdata[ST_RFAULT_BIT];
    end

    for (genvar g = 0; g < NUM_CAPS; g++) begin : g_caps
        // gather the capability bits from the status word
        assign caps[g] = mdio_rdata[CAP_BIT[g]];
    end

    pbu_adv_builder u_adv (
        .caps (caps),
        .adv  (adv_word)
    );

    pbu_poll_timer #(.TICKS(POLL_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (timer_run),
        .tick   (tick),
        .expire (timer_expire)
    );

    pbu_poll_budget #(.MAXN(BUDGET_MAX)) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bud_load),
        .load_val (bud_val),
        .dec      (bud_dec),
        .is_one   (bud_one),
        .is_zero  (bud_zero)
    );

    // timer runs only in the two wait states
    always_comb begin
        timer_run = (state == S_WAIT_RST) || (state == S_WAIT_AN);
    end

    // poll budget control: load at loop entry, decrement per failed poll
    always_comb begin
        bud_load = 1'b0;
        bud_val  = '0;
        bud_dec  = 1'b0;
        if (mdio_done) begin
            case (state)
                S_WR_RST:  begin bud_load = 1'b1; bud_val = BW'(RST_POLLS); end
                S_WR_ANEG: begin bud_load = 1'b1; bud_val = BW'(AN_POLLS);  end
                S_RD_CTRL: bud_dec = rst_busy;
                S_RD_STAT: bud_dec = !an_ack;
                default:   ;
            endcase
        end
    end

    // request fields follow the current access state
    always_comb begin
        mdio_req   = 1'b1;
        mdio_wr    = 1'b0;
        mdio_reg   = CTRL_REG;
        mdio_wdata = '0;
        case (state)
            S_WR_RST:   begin mdio_wr = 1'b1; mdio_wdata = CTRL_RESET_WORD; end
            S_RD_CTRL:  ;
            S_WR_MASK:  begin mdio_wr = 1'b1; mdio_reg = MASK_REG; mdio_wdata = MASK_ALL; end
            S_RD_CAPS:  mdio_reg = STAT_REG;
            S_WR_ADV:   begin mdio_wr = 1'b1; mdio_reg = ADV_REG; mdio_wdata = adv_q; end
            S_RD_ADV:   mdio_reg = ADV_REG;
            S_WR_ANEG:  begin mdio_wr = 1'b1; mdio_wdata = CTRL_ANEG_WORD; end
            S_RD_STAT:  mdio_reg = STAT_REG;
            S_WR_FORCE: begin mdio_wr = 1'b1; mdio_wdata = CTRL_FORCE_WORD; end
            default:    mdio_req = 1'b0;
        endcase
    end

    // done flag straight from the final state
    always_comb begin
        bring_done = (state == S_DONE);
    end

    // main sequencing and outcome flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            adv_q        <= '0;
            link_up      <= 1'b0;
            rst_timeout  <= 1'b0;
            aneg_timeout <= 1'b0;
            remote_fault <= 1'b0;
        end else begin
            case (state)
                S_IDLE, S_DONE: begin
                    if (start) begin
                        state        <= S_WR_RST;
                        link_up      <= 1'b0;
                        rst_timeout  <= 1'b0;
                        aneg_timeout <= 1'b0;
                        remote_fault <= 1'b0;
                    end
                end
                S_WR_RST: if (mdio_done) state <= S_RD_CTRL;
                S_RD_CTRL: begin
                    if (mdio_done) begin
                        if (!rst_busy) begin
                            state <= S_WR_MASK;
                        end else if (bud_one) begin
                            state       <= S_DONE;
                            rst_timeout <= 1'b1;
                        end else begin
                            state <= S_WAIT_RST;
                        end
                    end
                end
                S_WAIT_RST: if (timer_expire) state <= S_RD_CTRL;
                S_WR_MASK:  if (mdio_done) state <= S_RD_CAPS;
                S_RD_CAPS: begin
                    if (mdio_done) begin
                        adv_q <= adv_word;
                        state <= S_WR_ADV;
                    end
                end
                S_WR_ADV:  if (mdio_done) state <= S_RD_ADV;
                S_RD_ADV:  if (mdio_done) state <= S_WR_ANEG;
                S_WR_ANEG: if (mdio_done) state <= S_RD_STAT;
                S_RD_STAT: begin
                    if (mdio_done) begin
                        remote_fault <= an_fault;
                        if (an_ack) begin
                            state   <= S_DONE;
                            link_up <= !an_fault;
                        end else if (an_fault) begin
                            state <= S_WR_FORCE;
                        end else if (bud_one) begin
                            state        <= S_DONE;
                            aneg_timeout <= 1'b1;
                        end else begin
                            state <= S_WAIT_AN;
                        end
                    end
                end
                S_WR_FORCE: begin
                    if (mdio_done) begin
                        if (bud_zero) begin
                            state        <= S_DONE;
                            aneg_timeout <= 1'b1;
                        end else begin
                            state <= S_WAIT_AN;
                        end
                    end
                end
                S_WAIT_AN: if (timer_expire) state <= S_RD_STAT;
                default:   state <= S_IDLE;
            endcase
        end
    end

    a_r12_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_done) |=> (mdio_req && $stable(mdio_reg)
                                      && $stable(mdio_wr) && $stable(mdio_wdata)));

    a_r11_link_clean: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> (bring_done && !rst_timeout && !aneg_timeout && !remote_fault));

    a_r4_one_timeout_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_timeout && aneg_timeout));

    a_r1_quiet_when_finished: assert property (@(posedge clk) disable iff (!rst_n)
        (bring_done || state == S_IDLE) |-> !mdio_req);

    a_r13_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bring_done && start) |=> (!bring_done && !link_up && !rst_timeout
                                   && !aneg_timeout && !remote_fault));

    a_r9_force_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_STAT && mdio_done && !an_ack && an_fault)
            |=> (mdio_req && mdio_wr && mdio_wdata == CTRL_FORCE_WORD));

endmodule

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;

    localparam int PT   = 2;
    localparam int RP   = 6;
    localparam int AT   = 3;
    localparam int AB   = 2 * AT;
    localparam int LAT  = 3;
    localparam int TDIV = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tick = 1'b0;
    logic        mdio_done = 1'b0;
    logic [15:0] mdio_rdata = '0;
    logic        mdio_req, mdio_wr;
    logic [4:0]  mdio_reg;
    logic [15:0] mdio_wdata;
    logic        bring_done, link_up, rst_timeout, aneg_timeout, remote_fault;

    always #5 clk = ~clk;

    phy_bringup_seq #(.POLL_TICKS(PT), .RST_POLLS(RP), .ANEG_TIMEOUT(AT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_reg(mdio_reg),
        .mdio_wdata(mdio_wdata), .mdio_rdata(mdio_rdata), .mdio_done(mdio_done),
        .bring_done(bring_done), .link_up(link_up), .rst_timeout(rst_timeout),
        .aneg_timeout(aneg_timeout), .remote_fault(remote_fault)
    );

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int tick_count = 0;
    int tdiv = 0;
    int pend = 0;
    int req_tick = 0;

    // PHY scenario knobs
    int sc_rc, sc_caps, sc_ack, sc_fm;
    int ctrl_reads, stat_reads;
    logic [15:0] adv_store;

    // observed access log
    int          lg_n;
    logic        lg_w [64];
    logic [4:0]  lg_r [64];
    logic [15:0] lg_d [64];
    int          lg_t [64];

    // expected access list
    int          en;
    logic        e_w [64];
    logic [4:0]  e_r [64];
    logic [15:0] e_d [64];
    string       e_tag [64];
    logic        e_gap [64];
    logic x_link, x_rto, x_ato, x_fault;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] phy_read(input logic [4:0] r);
        logic [15:0] d;
        int j;
        d = '0;
        if (r == 5'd0) begin
            d = (ctrl_reads < sc_rc) ? 16'h8000 : 16'h0000;
            ctrl_reads++;
        end else if (r == 5'd1) begin
            d = 16'(sc_caps) << 11;
            if (stat_reads > 0) begin
                j = stat_reads - 1;
                if (j >= sc_ack) d = d | 16'h0020;
                if (((sc_fm >> j) & 1) != 0) d = d | 16'h0010;
            end
            stat_reads++;
        end else if (r == 5'd4) begin
            d = adv_store;
        end
        return d;
    endfunction

    // timebase, cycle count and PHY/MDIO-master model, all at the falling edge
    initial begin : env
        forever begin
            @(negedge clk);
            cyc++;
            tdiv = (tdiv + 1) % TDIV;
            tick = (tdiv == 0);
            if (tick) tick_count++;
            if (mdio_done) begin
                mdio_done = 1'b0;
                pend = 0;
            end else if (mdio_req) begin
                pend++;
                if (pend == 1) req_tick = tick_count;
                if (pend == LAT) begin
                    if (lg_n < 64) begin
                        lg_w[lg_n] = mdio_wr;
                        lg_r[lg_n] = mdio_reg;
                        lg_d[lg_n] = mdio_wdata;
                        lg_t[lg_n] = req_tick;
                    end
                    lg_n++;
                    if (mdio_wr) begin
                        if (mdio_reg == 5'd4) adv_store = mdio_wdata;
                    end else begin
                        mdio_rdata = phy_read(mdio_reg);
                    end
                    mdio_done = 1'b1;
                end
            end
        end
    end

    task automatic add(input logic w, input logic [4:0] r, input logic [15:0] d,
                       input string tag, input logic gap);
        e_w[en] = w; e_r[en] = r; e_d[en] = d; e_tag[en] = tag; e_gap[en] = gap;
        en++;
    endtask

    task automatic build_expected();
        bit cleared;
        bit acked;
        logic lastf;
        logic [15:0] adv;
        en = 0; x_link = 0; x_rto = 0; x_ato = 0; x_fault = 0;
        add(1'b1, 5'd0, 16'h8000, "R2", 1'b0);
        cleared = 0;
        for (int i = 0; i < RP; i++) begin
            add(1'b0, 5'd0, 16'h0, (i == RP - 1) ? "R4" : "R3", i > 0);
            if (i >= sc_rc) begin cleared = 1; break; end
        end
        if (!cleared) begin x_rto = 1; return; end
        add(1'b1, 5'd19, 16'hFFFF, "R5", 1'b0);
        add(1'b0, 5'd1, 16'h0, "R5", 1'b0);
        adv = 16'h0001;
        if (sc_caps[4]) adv = adv | 16'h0200;
        if (sc_caps[3]) adv = adv | 16'h0100;
        if (sc_caps[2]) adv = adv | 16'h0080;
        if (sc_caps[1]) adv = adv | 16'h0040;
        if (sc_caps[0]) adv = adv | 16'h0020;
        add(1'b1, 5'd4, adv, "R6", 1'b0);
        add(1'b0, 5'd4, 16'h0, "R6", 1'b0);
        add(1'b1, 5'd0, 16'h1200, "R7", 1'b0);
        acked = 0; lastf = 0;
        for (int j = 0; j < AB; j++) begin
            add(1'b0, 5'd1, 16'h0, "R8", j > 0);
            lastf = ((sc_fm >> j) & 1) != 0;
            if (j >= sc_ack) begin acked = 1; break; end
            if (lastf) add(1'b1, 5'd0, 16'h3300, "R9", 1'b0);
        end
        x_fault = lastf;
        if (acked) x_link = !lastf;
        else x_ato = 1;
    endtask

    task automatic run_case(input int rc, input int caps, input int ack,
                            input int fm, input bit poke);
        int guard;
        int gap;
        int lim;
        sc_rc = rc; sc_caps = caps; sc_ack = ack; sc_fm = fm;
        ctrl_reads = 0; stat_reads = 0; lg_n = 0;
        build_expected();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(bring_done == 1'b0 && link_up == 1'b0 && rst_timeout == 1'b0 &&
            aneg_timeout == 1'b0 && remote_fault == 1'b0,
            "R13", "flags after start", int'(bring_done), 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        guard = 0;
        while (!bring_done && guard < 5000) begin
            @(negedge clk); guard++;
        end
        repeat (30) @(negedge clk);
        chk(lg_n == en, x_rto ? "R4" : (x_ato ? "R10" : "R12"), "access count", lg_n, en);
        lim = (lg_n < en) ? lg_n : en;
        if (lim > 64) lim = 64;
        for (int k = 0; k < lim; k++) begin
            chk(lg_w[k] == e_w[k] && lg_r[k] == e_r[k] && (!e_w[k] || lg_d[k] == e_d[k]),
                e_tag[k], "access {wr,reg,data}",
                int'({lg_w[k], 3'b0, lg_r[k], lg_d[k]}),
                int'({e_w[k], 3'b0, e_r[k], e_w[k] ? e_d[k] : lg_d[k]}));
            if (e_gap[k] && k > 0) begin
                gap = lg_t[k] - lg_t[k-1];
                chk(gap >= PT && gap <= PT + 1, (e_r[k] == 5'd0) ? "R3" : "R8",
                    "poll spacing in ticks", gap, PT);
            end
        end
        chk(bring_done == 1'b1, "R11", "bring_done", int'(bring_done), 1);
        chk(link_up == x_link, "R11", "link_up", int'(link_up), int'(x_link));
        chk(rst_timeout == x_rto, "R4", "rst_timeout", int'(rst_timeout), int'(x_rto));
        chk(aneg_timeout == x_ato, "R10", "aneg_timeout", int'(aneg_timeout), int'(x_ato));
        chk(remote_fault == x_fault, "R11", "remote_fault", int'(remote_fault), int'(x_fault));
    endtask

    // watchdog: a hung run counts as a failure and still summarises
    initial begin : watchdog
        while (cyc < 150000) @(negedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin : main
        lg_n = 0;
        adv_store = '0;
        sc_rc = 0; sc_caps = 0; sc_ack = 0; sc_fm = 0;
        ctrl_reads = 0; stat_reads = 0;
        repeat (3) @(negedge clk);
        // R1: state under reset
        chk(!mdio_req && !bring_done && !link_up && !rst_timeout && !aneg_timeout
            && !remote_fault, "R1", "outputs in reset", int'(mdio_req), 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(!mdio_req && !bring_done && lg_n == 0, "R1", "idle after reset",
            int'(mdio_req), 0);

        // R3/R4: every reset-clear position, including timeout
        for (int rc = 0; rc <= RP; rc++) run_case(rc, 5'h1F, 0, 0, 1'b0);
        // R6: all capability patterns
        for (int c = 0; c < 32; c++) run_case(1, c, 1, 0, 1'b0);
        // R8/R10: every acknowledge position, including exhaustion
        for (int a = 0; a <= AB; a++) run_case(0, 5'b01010, a, 0, 1'b0);
        // R9/R11: remote-fault patterns
        run_case(0, 5'b10001, 3, 6'b000010, 1'b0);
        run_case(2, 5'b00111, 99, 6'b111111, 1'b0);
        run_case(0, 5'b11000, 2, 6'b000100, 1'b0);
        run_case(1, 5'b01100, 99, 6'b010101, 1'b0);
        // R13: start while busy is ignored
        run_case(3, 5'b10101, 2, 6'b000001, 1'b1);
        run_case(RP, 5'b00001, 0, 0, 1'b1);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule